// File: doc/BRIEF.md
# Oversampled SPI Bus Monitor

This block watches the four lines of an SPI bus (serial clock, the two data lines and the select line) from a faster system clock and never drives any of them. Each line passes through a two-stage synchroniser. The serial clock is then compared with its value one system cycle earlier to find edges. Only the edge that the chosen clock polarity and phase call for moves a bit into the word being assembled. Word length, bit order and select polarity are runtime settings. Each line can also be marked as present or absent.

For every completed word the block offers one record on a valid/ready output. The record holds both data words, a present flag for each data line, a warning flag, and the word's duration measured in system-clock samples. Downstream logic can derive the bit rate from that duration. Every level change on the select line also produces a one-cycle event carrying the old and new levels.

A tool that uses the block sets the configuration inputs while the block is held in reset and leaves them stable afterwards. It then collects records and select events as they appear.

Top module: `spi_bus_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs `rec_valid`, `evt_valid` and `overflow` are low after that edge.
- R2: A data bit is taken on a rising serial-clock edge (0 to 1) when `cfg_cpol` equals `cfg_cpha`, and on a falling edge (1 to 0) otherwise. The opposite edge takes no bit.
- R3: The word length is `cfg_word_len`, from 1 to MAX_W bits. A record is produced when the bit with that number has been taken. A line change sampled at system edge t reaches `rec_*` and `evt_*` at edge t+2.
- R4: With `cfg_lsb_first` low, bit k of a word (0 = first on the wire) lands at position `cfg_word_len`-1-k. With it high, bit k lands at position k. Positions at or above `cfg_word_len` read 0.
- R5: With `cfg_sel_present` high, each level change of the select line gives one cycle of `evt_valid`, with `evt_old` and `evt_new` holding the line level before and after the change.
- R6: A select change discards the partly assembled word on both data lines. A bit taken in the same cycle becomes bit 0 of a new word.
- R7: With `cfg_sel_present` low, select changes give no event and discard nothing, so a word may span them.
- R8: A data line marked absent gives a record whose `_ok` flag is 0 and whose data field is 0. The other line is assembled normally.
- R9: `rec_dur` equals the sample index of the word's last bit minus that of its first bit, plus 1. The sample index counts system cycles.
- R10: If the select line moves to its inactive level while at least one bit of a word is held (with select present), the next record has `rec_warn` = 1. The record after that has `rec_warn` = 0 unless the condition occurs again.
- R11: `cfg_sel_act_high` high makes level 0 the inactive select level for R10; low makes level 1 inactive.
- R12: A record with `rec_valid` high and `rec_ready` low holds its contents unchanged. A word that completes at that time is dropped and sets `overflow`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_clk_i | input | 1 | Observed serial clock line |
| bus_mosi_i | input | 1 | Observed controller-to-peripheral data line |
| bus_miso_i | input | 1 | Observed peripheral-to-controller data line |
| bus_sel_i | input | 1 | Observed select line |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_lsb_first | input | 1 | 1: first bit on the wire is the least significant |
| cfg_word_len | input | LEN_W | Bits per word, 1 to MAX_W |
| cfg_sel_act_high | input | 1 | 1: select is active high |
| cfg_sel_present | input | 1 | Select line is connected |
| cfg_mosi_present | input | 1 | Controller-to-peripheral line is connected |
| cfg_miso_present | input | 1 | Peripheral-to-controller line is connected |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Record taken by consumer |
| rec_mosi | output | MAX_W | Controller-to-peripheral word |
| rec_miso | output | MAX_W | Peripheral-to-controller word |
| rec_mosi_ok | output | 1 | Controller-to-peripheral field is meaningful |
| rec_miso_ok | output | 1 | Peripheral-to-controller field is meaningful |
| rec_warn | output | 1 | Select went inactive during this word |
| rec_dur | output | IDX_W | Word duration in system samples |
| evt_valid | output | 1 | Select change event, one cycle |
| evt_old | output | 1 | Select level before the change |
| evt_new | output | 1 | Select level after the change |
| overflow | output | 1 | Sticky: a record was lost |

## Verification
The internal state that matters is the bit counter, the two partial words, the first-bit sample index and the pending warning. None of these is visible except through the next record. A wrong counter shows up as a record raised one edge early or late, or one that never arrives. It is seen at the first record after the fault, two system cycles after the final active edge. A stale partial word or a missed discard shows up as wrong data bits in that same record. A lost first-bit index shows up as a wrong `rec_dur`, and a pending warning that is never cleared shows up as `rec_warn` set on the record that follows. The bench predicts every output on every cycle, so any of these faults is reported on the cycle the record appears.

// File: rtl/spi_mon_pkg.sv
// Shared definitions for the SPI bus monitor.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package spi_mon_pkg;

    // Which serial-clock transition carries data.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_kind_e;

    // Lane positions inside the synchroniser vector.
    localparam int LN_CLK   = 0;
    localparam int LN_MOSI  = 1;
    localparam int LN_MISO  = 2;
    localparam int LN_SEL   = 3;
    localparam int LN_COUNT = 4;

    // Rising edge when polarity equals phase (modes 0 and 3), else falling.
    function automatic edge_kind_e sample_edge(input logic cpol, input logic cpha);
        return (cpol == cpha) ? EDGE_RISE : EDGE_FALL;
    endfunction

endpackage

// File: rtl/spi_mon_sync.sv
// Two-flop synchroniser for a vector of asynchronous lines.
// Assumes: each lane is independent; rst_val gives the idle level each lane
// should hold during reset so that no false edge is seen afterwards.
module spi_mon_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= rst_val[g];
                stab_q <= rst_val[g];
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
            end
        end

        assign sync_out[g] = stab_q;
    end

endmodule

// File: rtl/spi_mon_edge.sv
// Edge finder: detects the data-carrying serial clock edge and select changes.
// Assumes: inputs are already synchronised; configuration is static after reset.
module spi_mon_edge
    import spi_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    input  logic line_sel,
    input  logic cfg_cpol,
    input  logic cfg_cpha,
    input  logic cfg_sel_present,
    input  logic cfg_sel_act_high,
    output logic bit_stb,
    output logic sel_chg,
    output logic sel_drop,
    output logic sel_prev
);

    logic       clk_q;
    logic       sel_q;
    edge_kind_e kind;

    // Remember last sampled clock and select levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= cfg_cpol;
            sel_q <= ~cfg_sel_act_high;
        end else begin
            clk_q <= line_clk;
            sel_q <= line_sel;
        end
    end

    // Classify the current sample against the previous one.
    always_comb begin
        kind     = sample_edge(cfg_cpol, cfg_cpha);
        bit_stb  = (line_clk != clk_q) &&
                   ((kind == EDGE_RISE) ? line_clk : !line_clk);
        sel_chg  = cfg_sel_present && (line_sel != sel_q);
        sel_drop = sel_chg && (line_sel == ~cfg_sel_act_high);
        sel_prev = sel_q;
    end

endmodule

// File: rtl/spi_mon_shift.sv
// Word assembler: places bits into both data words, tracks first-bit index,
// pending warning and completion.
// Assumes: 1 <= cfg_word_len <= MAX_W; configuration static after reset.
module spi_mon_shift #(
    parameter int MAX_W = 16,
    parameter int IDX_W = 24,
    localparam int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             sel_chg,
    input  logic             sel_drop,
    input  logic             mosi_bit,
    input  logic             miso_bit,
    input  logic             cfg_lsb_first,
    input  logic [LEN_W-1:0] cfg_word_len,
    input  logic             cfg_mosi_present,
    input  logic             cfg_miso_present,
    input  logic [IDX_W-1:0] sample_idx,
    output logic             word_done,
    output logic [MAX_W-1:0] word_mosi,
    output logic [MAX_W-1:0] word_miso,
    output logic             word_warn,
    output logic [IDX_W-1:0] word_dur
);

    logic [LEN_W-1:0] cnt_q, base_cnt, slot;
    logic [MAX_W-1:0] mo_q, mi_q, mo_base, mi_base, mo_next, mi_next;
    logic [IDX_W-1:0] first_q, first_now;
    logic             warn_q, warn_now;

    // Next word contents, completion and duration for this sample.
    always_comb begin
        base_cnt = sel_chg ? '0 : cnt_q;
        mo_base  = sel_chg ? '0 : mo_q;
        mi_base  = sel_chg ? '0 : mi_q;
        slot     = cfg_lsb_first ? base_cnt
                                 : (cfg_word_len - LEN_W'(1) - base_cnt);
        mo_next  = mo_base;
        mi_next  = mi_base;
        for (int i = 0; i < MAX_W; i++) begin
            if (slot == LEN_W'(i)) begin
                if (cfg_mosi_present) mo_next[i] = mosi_bit;
                if (cfg_miso_present) mi_next[i] = miso_bit;
            end
        end
        first_now = (base_cnt == '0) ? sample_idx : first_q;
        warn_now  = warn_q | (sel_drop && (cnt_q != '0));
        word_done = bit_stb && ((base_cnt + LEN_W'(1)) == cfg_word_len);
        word_mosi = mo_next;
        word_miso = mi_next;
        word_warn = warn_now;
        word_dur  = sample_idx - first_now + IDX_W'(1);
    end

    // Advance counter and partial words; clear on completion or select change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            mo_q    <= '0;
            mi_q    <= '0;
            first_q <= '0;
            warn_q  <= 1'b0;
        end else begin
            if (bit_stb) begin
                first_q <= first_now;
                if (word_done) begin
                    cnt_q <= '0;
                    mo_q  <= '0;
                    mi_q  <= '0;
                end else begin
                    cnt_q <= base_cnt + LEN_W'(1);
                    mo_q  <= mo_next;
                    mi_q  <= mi_next;
                end
            end else if (sel_chg) begin
                cnt_q <= '0;
                mo_q  <= '0;
                mi_q  <= '0;
            end
            warn_q <= word_done ? 1'b0 : warn_now;
        end
    end

endmodule

// File: rtl/spi_bus_monitor.sv
// Passive SPI bus monitor: synchronises the bus lines, finds sampling edges,
// assembles words and offers one record per word plus select-change events.
// Assumes: configuration inputs are set during reset and held afterwards;
// at least one data line is marked present.
module spi_bus_monitor
    import spi_mon_pkg::*;
#(
    parameter int MAX_W = 16,
    parameter int IDX_W = 24,
    localparam int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_clk_i,
    input  logic             bus_mosi_i,
    input  logic             bus_miso_i,
    input  logic             bus_sel_i,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic [LEN_W-1:0] cfg_word_len,
    input  logic             cfg_sel_act_high,
    input  logic             cfg_sel_present,
    input  logic             cfg_mosi_present,
    input  logic             cfg_miso_present,
    output logic             rec_valid,
    input  logic             rec_ready,
    output logic [MAX_W-1:0] rec_mosi,
    output logic [MAX_W-1:0] rec_miso,
    output logic             rec_mosi_ok,
    output logic             rec_miso_ok,
    output logic             rec_warn,
    output logic [IDX_W-1:0] rec_dur,
    output logic             evt_valid,
    output logic             evt_old,
    output logic             evt_new,
    output logic             overflow
);

    logic [LN_COUNT-1:0] raw_v, idle_v, syn_v;
    logic [IDX_W-1:0]    idx_q;
    logic                bit_stb, sel_chg, sel_drop, sel_prev;
    logic                word_done, word_warn;
    logic [MAX_W-1:0]    word_mosi, word_miso;
    logic [IDX_W-1:0]    word_dur;

    // Gather lines and their idle levels into lane vectors.
    always_comb begin
        raw_v[LN_CLK]   = bus_clk_i;
        raw_v[LN_MOSI]  = bus_mosi_i;
        raw_v[LN_MISO]  = bus_miso_i;
        raw_v[LN_SEL]   = bus_sel_i;
        idle_v[LN_CLK]  = cfg_cpol;
        idle_v[LN_MOSI] = 1'b0;
        idle_v[LN_MISO] = 1'b0;
        idle_v[LN_SEL]  = ~cfg_sel_act_high;
    end

    spi_mon_sync #(.WIDTH(LN_COUNT)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_val  (idle_v),
        .async_in (raw_v),
        .sync_out (syn_v)
    );

    spi_mon_edge edge_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .line_clk         (syn_v[LN_CLK]),
        .line_sel         (syn_v[LN_SEL]),
        .cfg_cpol         (cfg_cpol),
        .cfg_cpha         (cfg_cpha),
        .cfg_sel_present  (cfg_sel_present),
        .cfg_sel_act_high (cfg_sel_act_high),
        .bit_stb          (bit_stb),
        .sel_chg          (sel_chg),
        .sel_drop         (sel_drop),
        .sel_prev         (sel_prev)
    );

    spi_mon_shift #(.MAX_W(MAX_W), .IDX_W(IDX_W)) shift_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .bit_stb          (bit_stb),
        .sel_chg          (sel_chg),
        .sel_drop         (sel_drop),
        .mosi_bit         (syn_v[LN_MOSI]),
        .miso_bit         (syn_v[LN_MISO]),
        .cfg_lsb_first    (cfg_lsb_first),
        .cfg_word_len     (cfg_word_len),
        .cfg_mosi_present (cfg_mosi_present),
        .cfg_miso_present (cfg_miso_present),
        .sample_idx       (idx_q),
        .word_done        (word_done),
        .word_mosi        (word_mosi),
        .word_miso        (word_miso),
        .word_warn        (word_warn),
        .word_dur         (word_dur)
    );

    // Free-running sample index in system cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_q + IDX_W'(1);
    end

    // Select-change event register, one cycle per change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_old   <= 1'b0;
            evt_new   <= 1'b0;
        end else begin
            evt_valid <= sel_chg;
            evt_old   <= sel_prev;
            evt_new   <= syn_v[LN_SEL];
        end
    end

    // Record register with valid/ready hold and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid   <= 1'b0;
            rec_mosi    <= '0;
            rec_miso    <= '0;
            rec_mosi_ok <= 1'b0;
            rec_miso_ok <= 1'b0;
            rec_warn    <= 1'b0;
            rec_dur     <= '0;
            overflow    <= 1'b0;
        end else if (word_done) begin
            if (rec_valid && !rec_ready) begin
                overflow <= 1'b1;
            end else begin
                rec_valid   <= 1'b1;
                rec_mosi    <= cfg_mosi_present ? word_mosi : '0;
                rec_miso    <= cfg_miso_present ? word_miso : '0;
                rec_mosi_ok <= cfg_mosi_present;
                rec_miso_ok <= cfg_miso_present;
                rec_warn    <= word_warn;
                rec_dur     <= word_dur;
            end
        end else if (rec_valid && rec_ready) begin
            rec_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_bus_monitor_chk.sv
// Property checker for the SPI bus monitor, attached by bind.
// Assumes: observes top-level ports only.
module spi_bus_monitor_chk #(
    parameter int MAX_W = 16,
    parameter int IDX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_sel_present,
    input logic             rec_valid,
    input logic             rec_ready,
    input logic [MAX_W-1:0] rec_mosi,
    input logic [MAX_W-1:0] rec_miso,
    input logic             rec_mosi_ok,
    input logic             rec_miso_ok,
    input logic [IDX_W-1:0] rec_dur,
    input logic             evt_valid,
    input logic             evt_old,
    input logic             evt_new,
    input logic             overflow
);

    AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> rec_valid); // R12
    AST_REC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> $stable(rec_mosi) && $stable(rec_miso) && $stable(rec_dur)); // R12
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R12
    AST_EVT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_old != evt_new)); // R5
    AST_NO_EVT_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_sel_present) |-> !evt_valid); // R7
    AST_MOSI_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_mosi_ok |-> (rec_mosi == '0)); // R8
    AST_MISO_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_miso_ok |-> (rec_miso == '0)); // R8
    AST_DUR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_dur != '0)); // R9

endmodule

bind spi_bus_monitor spi_bus_monitor_chk #(.MAX_W(MAX_W), .IDX_W(IDX_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_sel_present (cfg_sel_present),
    .rec_valid       (rec_valid),
    .rec_ready       (rec_ready),
    .rec_mosi        (rec_mosi),
    .rec_miso        (rec_miso),
    .rec_mosi_ok     (rec_mosi_ok),
    .rec_miso_ok     (rec_miso_ok),
    .rec_dur         (rec_dur),
    .evt_valid       (evt_valid),
    .evt_old         (evt_old),
    .evt_new         (evt_new),
    .overflow        (overflow)
);

// File: tb/spi_bus_monitor_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle reference model plus directed literal checks.
module spi_bus_monitor_tb_top;

    localparam int MAXW = 16;
    localparam int IDXW = 24;
    localparam int LENW = $clog2(MAXW + 1);
    localparam int H    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic r_clk = 1'b0, r_mo = 1'b0, r_mi = 1'b0, r_sel = 1'b1;
    logic c_cpol = 1'b0, c_cpha = 1'b0, c_lsb = 1'b0, c_acth = 1'b0;
    logic c_selp = 1'b1, c_mop = 1'b1, c_mip = 1'b1;
    logic [LENW-1:0] c_len = LENW'(8);
    logic ready_r = 1'b1;

    logic            rec_valid, rec_mosi_ok, rec_miso_ok, rec_warn;
    logic [MAXW-1:0] rec_mosi, rec_miso;
    logic [IDXW-1:0] rec_dur;
    logic            evt_valid, evt_old, evt_new, overflow;

    always #2 clk = ~clk;

    spi_bus_monitor #(.MAX_W(MAXW), .IDX_W(IDXW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_clk_i(r_clk), .bus_mosi_i(r_mo), .bus_miso_i(r_mi), .bus_sel_i(r_sel),
        .cfg_cpol(c_cpol), .cfg_cpha(c_cpha), .cfg_lsb_first(c_lsb), .cfg_word_len(c_len),
        .cfg_sel_act_high(c_acth), .cfg_sel_present(c_selp),
        .cfg_mosi_present(c_mop), .cfg_miso_present(c_mip),
        .rec_valid(rec_valid), .rec_ready(ready_r), .rec_mosi(rec_mosi), .rec_miso(rec_miso),
        .rec_mosi_ok(rec_mosi_ok), .rec_miso_ok(rec_miso_ok), .rec_warn(rec_warn),
        .rec_dur(rec_dur), .evt_valid(evt_valid), .evt_old(evt_old), .evt_new(evt_new),
        .overflow(overflow)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [3:0] hist[$];
    int m_idx, m_cnt, m_first;
    logic [MAXW-1:0] m_mo, m_mi;
    bit m_warn;
    bit e_valid, e_mook, e_miok, e_warn, e_evt, e_old, e_new, e_ovf;
    logic [MAXW-1:0] e_mo, e_mi;
    int e_dur;
    bit started = 0;

    always @(posedge clk) begin
        logic [3:0] cur, prv, idle;
        bit strobe, chg, drop, done, wn;
        int pos;
        idle = {~c_acth, 1'b0, 1'b0, c_cpol};
        if (!rst_n) begin
            started = 1;
            hist = '{idle, idle, idle};
            m_idx = 0; m_cnt = 0; m_first = 0; m_mo = '0; m_mi = '0; m_warn = 0;
            e_valid = 0; e_evt = 0; e_ovf = 0;
        end else begin
            cur = hist[1];
            prv = hist[0];
            strobe = (cur[0] != prv[0]) && (cur[0] == (c_cpol == c_cpha));
            chg    = c_selp && (cur[3] != prv[3]);
            drop   = chg && (cur[3] == !c_acth);
            wn     = m_warn || (drop && m_cnt != 0);
            if (chg) begin m_cnt = 0; m_mo = '0; m_mi = '0; end
            done = 0;
            if (strobe) begin
                if (m_cnt == 0) m_first = m_idx;
                pos = c_lsb ? m_cnt : int'(c_len) - 1 - m_cnt;
                if (c_mop && cur[1]) m_mo[pos] = 1'b1;
                if (c_mip && cur[2]) m_mi[pos] = 1'b1;
                m_cnt++;
                if (m_cnt == int'(c_len)) done = 1;
            end
            e_evt = chg; e_old = prv[3]; e_new = cur[3];
            if (done) begin
                if (e_valid && !ready_r) e_ovf = 1;
                else begin
                    e_valid = 1; e_mo = c_mop ? m_mo : '0; e_mi = c_mip ? m_mi : '0;
                    e_mook = c_mop; e_miok = c_mip; e_warn = wn; e_dur = m_idx - m_first + 1;
                end
                m_cnt = 0; m_mo = '0; m_mi = '0;
            end else if (e_valid && ready_r) e_valid = 0;
            m_warn = done ? 0 : wn;
            hist.push_back({r_sel, r_mi, r_mo, r_clk});
            void'(hist.pop_front());
            m_idx++;
        end
    end

    // ---------------- per-cycle comparison and capture ----------------
    typedef struct { logic [MAXW-1:0] mo, mi; bit mook, miok, warn; int dur; } rec_s;
    rec_s got[$];
    int n_evt = 0;

    always @(negedge clk) begin
        if (started) begin
            chk(rec_valid === e_valid, "R3 rec_valid timing", rec_valid, e_valid);
            if (e_valid) begin
                chk(rec_mosi === e_mo, "R4 rec_mosi", rec_mosi, e_mo);
                chk(rec_miso === e_mi, "R4 rec_miso", rec_miso, e_mi);
                chk(rec_mosi_ok === e_mook && rec_miso_ok === e_miok, "R8 ok flags",
                    {rec_mosi_ok, rec_miso_ok}, {e_mook, e_miok});
                chk(rec_warn === e_warn, "R10 rec_warn", rec_warn, e_warn);
                chk(rec_dur === IDXW'(e_dur), "R9 rec_dur", rec_dur, e_dur);
            end
            chk(evt_valid === e_evt, "R5 evt_valid", evt_valid, e_evt);
            if (e_evt) chk(evt_old === e_old && evt_new === e_new, "R5 evt levels",
                           {evt_old, evt_new}, {e_old, e_new});
            chk(overflow === e_ovf, "R12 overflow", overflow, e_ovf);
            if (rec_valid && ready_r)
                got.push_back('{rec_mosi, rec_miso, rec_mosi_ok, rec_miso_ok, rec_warn, int'(rec_dur)});
            if (evt_valid) n_evt++;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        r_clk = c_cpol; r_sel = ~c_acth; r_mo = 1'b0; r_mi = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        got.delete();
        n_evt = 0;
    endtask

    task automatic sel_set(input bit active);
        r_sel = active ? c_acth : ~c_acth;
        wait_n(H);
    endtask

    task automatic xfer(input int n, input logic [MAXW-1:0] mo, input logic [MAXW-1:0] mi);
        bit lvl;
        lvl = (c_cpol == c_cpha);
        for (int k = 0; k < n; k++) begin
            int b;
            b = c_lsb ? k : n - 1 - k;
            r_clk = ~lvl; r_mo = mo[b]; r_mi = mi[b];
            wait_n(H);
            r_clk = lvl;
            wait_n(H);
        end
        r_clk = c_cpol;
        wait_n(H);
        wait_n(4);
    endtask

    task automatic expect_rec(input int i, input string tag, input logic [MAXW-1:0] mo,
                              input logic [MAXW-1:0] mi, input bit warn);
        if (got.size() > i) begin
            chk(got[i].mo == mo, tag, got[i].mo, mo);
            chk(got[i].mi == mi, tag, got[i].mi, mi);
            chk(got[i].warn == warn, tag, got[i].warn, warn);
        end else chk(0, tag, got.size(), i + 1);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [MAXW-1:0] wa [4];
        wa = '{16'hA5, 16'h5A, 16'hC3, 16'h96};

        do_reset();
        // R1: reset state
        chk(rec_valid == 0 && evt_valid == 0 && overflow == 0, "R1 reset state",
            {rec_valid, evt_valid, overflow}, 0);

        // R2: all four modes, msb first, 8 bits
        for (int m = 0; m < 4; m++) begin
            c_cpol = m[1]; c_cpha = m[0];
            do_reset();
            sel_set(1);
            xfer(8, wa[m], ~wa[m] & 16'hFF);
            sel_set(0);
            wait_n(4);
            chk(got.size() == 1, "R2 one word per mode", got.size(), 1);
            expect_rec(0, "R2 mode data", wa[m], ~wa[m] & 16'hFF, 0);
            // R9: 8 bits, active edges 2H apart
            if (got.size() > 0) chk(got[0].dur == 7 * 2 * H + 1, "R9 duration", got[0].dur, 7 * 2 * H + 1);
            // R5: select on and off each give one event
            chk(n_evt == 2, "R5 event count", n_evt, 2);
        end

        // R4 and R3: lsb first, 5-bit word; then msb first 12-bit word
        c_cpol = 0; c_cpha = 0; c_lsb = 1; c_len = LENW'(5);
        do_reset();
        sel_set(1);
        xfer(5, 16'h13, 16'h0A);
        wait_n(4);
        expect_rec(0, "R4 lsb-first len5", 16'h13, 16'h0A, 0);
        c_lsb = 0; c_len = LENW'(12);
        do_reset();
        sel_set(1);
        xfer(12, 16'hABC, 16'h123);
        wait_n(4);
        expect_rec(0, "R3 len12", 16'hABC, 16'h123, 0);

        // R6, R10: select drop mid-word discards and flags next word
        c_len = LENW'(8);
        do_reset();
        sel_set(1);
        xfer(3, 16'h7, 16'h0);
        sel_set(0);
        sel_set(1);
        xfer(8, 16'h66, 16'h99);
        xfer(8, 16'h11, 16'h22);
        wait_n(4);
        expect_rec(0, "R6 R10 after drop", 16'h66, 16'h99, 1);
        expect_rec(1, "R10 warn cleared", 16'h11, 16'h22, 0);

        // R7: select absent, word spans select toggles, no events
        c_selp = 0;
        do_reset();
        xfer(3, 16'h5, 16'h0);
        sel_set(1);
        sel_set(0);
        xfer(5, 16'h13, 16'h0);
        wait_n(4);
        expect_rec(0, "R7 span", 16'hB3, 16'h00, 0);
        chk(n_evt == 0, "R7 no events", n_evt, 0);
        c_selp = 1;

        // R8: miso line absent
        c_mip = 0;
        do_reset();
        sel_set(1);
        xfer(8, 16'h3C, 16'hFF);
        wait_n(4);
        expect_rec(0, "R8 absent miso", 16'h3C, 16'h00, 0);
        if (got.size() > 0) chk(got[0].miok == 0 && got[0].mook == 1, "R8 ok flags",
                                {got[0].mook, got[0].miok}, 2'b10);
        c_mip = 1;

        // R11: active-high select, drop to 0 mid-word flags warning
        c_acth = 1;
        do_reset();
        sel_set(1);
        xfer(4, 16'hF, 16'hF);
        sel_set(0);
        sel_set(1);
        xfer(8, 16'h81, 16'h18);
        wait_n(4);
        expect_rec(0, "R11 active-high warn", 16'h81, 16'h18, 1);
        c_acth = 0;

        // R12: consumer stalls, second word dropped, overflow sticky
        do_reset();
        ready_r = 0;
        sel_set(1);
        xfer(8, 16'h42, 16'h24);
        xfer(8, 16'hEE, 16'hDD);
        chk(overflow == 1, "R12 overflow set", overflow, 1);
        chk(rec_valid == 1 && rec_mosi == 16'h42, "R12 held record", rec_mosi, 16'h42);
        ready_r = 1;
        wait_n(4);
        chk(got.size() == 1, "R12 one record delivered", got.size(), 1);
        expect_rec(0, "R12 first word kept", 16'h42, 16'h24, 0);
        chk(overflow == 1, "R12 overflow sticky", overflow, 1);

        wait_n(4);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule